// File: doc/BRIEF.md
# Card Status Input Port Controller

This block watches the status pins of a set of card sockets (two by default), eight pins per socket. Every pin passes through a two-flop synchronizer. A registered copy of the synchronized level is kept, and comparing the two gives one transition pulse per edge. For each pin, a per-pin mode selects which transitions set a sticky event flag. A per-pin enable then decides whether that flag contributes to the single interrupt output.

Software reads the synchronized pin levels directly and also reads a decoded view of the same pins: card presence, a three-level battery condition, write protect and the two voltage-sense bits. The top pin of each socket has a richer mode set than the other pins, which includes a level-sensitive option.

Each socket also drives a 16-bit I/O qualifier. The qualifier passes the socket's 16-bit-port pin only when the socket is switched to I/O mode and the addressed I/O window is declared 16 bits wide.

Top module: `csp_port_ctrl`

## Requirements
- R1: `bus_rdata` at offset 0 returns the socket's synchronized pin levels. A pin change driven between two clock edges is not visible after one rising edge and is visible after the second. Socket select is `bus_addr[3]` (0 = socket A on `pin_in[7:0]`, 1 = socket B on `pin_in[15:8]`), and the register offset is `bus_addr[2:0]`.
- R2: For pins 0 to 6, a 2-bit mode selects which edge sets the pin's event flag: 0 none, 1 falling, 2 rising, 3 either. The mode of pin n sits in bits [2n+1:2n] of a 16-bit mode word. The low byte of that word is written at offset 4 and the high byte at offset 5.
- R3: For pin 7, the mode at offset 5 bits [7:6] selects among four options: 0 falling, 1 rising, 2 either edge, 3 level-low. Level-low sets the flag on every cycle in which the synchronized pin is low.
- R4: Event flags at offset 2 are sticky. Writing 1 to a flag bit clears it, and writing 0 to it has no effect.
- R5: If a flag's trigger is active in the same cycle as a write of 1 to that flag, the flag remains set.
- R6: `irq` is high when, in any socket, some event flag is set and its enable bit (offset 3) is also set.
- R7: Offset 1 bit 0 reads 1 (card present) only when pins 3 and 4 are both low.
- R8: Offset 1 bits [2:1] give the battery condition from pins 6 and 5, where a high level means asserted. The code is 00 (good) when both are high, 01 (warning) when pin 6 is high and pin 5 is low, and 10 (dead) whenever pin 6 is low.
- R9: Offset 1 bit 3 carries the level of pin 2 (write protect), and bits [5:4] carry the levels of pins 1:0 (voltage sense).
- R10: `io16_q[s]` is 1 only when three conditions hold: offset 6 bit 0 (I/O mode) of socket s is 1, `io_win16[s]` is 1, and the synchronized pin 2 of socket s is low. When `io_win16[s]` is 0, the pin is ignored and the output is 0.
- R11: After reset, the event flags, enables, mode words and I/O mode bits are all zero, and `irq` and `io16_q` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 16 | Raw socket status pins, socket A in the low byte |
| io_win16 | input | 2 | Per socket: addressed I/O window is 16 bits wide |
| bus_addr | input | 4 | Register address: socket select and offset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request |
| io16_q | output | 2 | Per socket 16-bit I/O cycle qualifier |

## Verification
A pin change reaches the raw level, the decoded status and `io16_q` after two rising edges. It reaches the event flags and `irq` after three. A register write is visible on the first read after the edge that samples it, and `io_win16` acts combinationally. The bench drives inputs on falling edges. It samples raw levels exactly one and two edges after a change to pin down the synchronizer delay. For every flag and qualifier check, it waits three rising edges and then samples on the following falling edge.

// File: rtl/csp_pkg.sv
// Package: shared types and register offsets for the card status port.
// Assumes eight pins per socket with a fixed meaning for each pin index.
package csp_pkg;
    localparam int PINS_PER_SOCK = 8;

    // Pin roles inside one socket
    localparam int PIN_VS1  = 0;
    localparam int PIN_VS2  = 1;
    localparam int PIN_WP   = 2;
    localparam int PIN_CD2  = 3;
    localparam int PIN_CD1  = 4;
    localparam int PIN_BAT2 = 5;
    localparam int PIN_BAT1 = 6;
    localparam int PIN_EXT  = 7;

    // Register offsets inside one socket window
    localparam logic [2:0] OFF_RAW   = 3'd0;
    localparam logic [2:0] OFF_DEC   = 3'd1;
    localparam logic [2:0] OFF_EVT   = 3'd2;
    localparam logic [2:0] OFF_ENA   = 3'd3;
    localparam logic [2:0] OFF_MODLO = 3'd4;
    localparam logic [2:0] OFF_MODHI = 3'd5;
    localparam logic [2:0] OFF_CTL   = 3'd6;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_RISE = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_mode_e;

    typedef enum logic [1:0] {
        BATT_GOOD = 2'd0,
        BATT_WARN = 2'd1,
        BATT_DEAD = 2'd2
    } batt_e;
endpackage

// File: rtl/csp_edge_det.sv
// Module: synchronizes W pins with two flops and turns transitions into
// per-pin trigger pulses according to a 2-bit mode per pin.
// Assumes pins idle high; sync flops reset to 1 so reset makes no edge.
// Pin EXT_BIT uses the extended mode set (fall, rise, both, level-low).
module csp_edge_det
    import csp_pkg::*;
#(
    parameter int W       = 8,
    parameter int EXT_BIT = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   pin,
    input  logic [2*W-1:0] mode,
    output logic [W-1:0]   level,
    output logic [W-1:0]   hit
);
    logic [W-1:0] s1, s2, prev;

    // Two-stage synchronizer plus the delayed copy used for edge compare
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1   <= '1;
            s2   <= '1;
            prev <= '1;
        end else begin
            s1   <= pin;
            s2   <= s1;
            prev <= s2;
        end
    end

    assign level = s2;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic rise, fall;
        assign rise = s2[i] & ~prev[i];
        assign fall = ~s2[i] & prev[i];

        if (i == EXT_BIT) begin : g_ext
            // Extended selection: fall, rise, either, level-low
            always_comb begin
                case (mode[2*i +: 2])
                    2'd0:    hit[i] = fall;
                    2'd1:    hit[i] = rise;
                    2'd2:    hit[i] = rise | fall;
                    default: hit[i] = ~s2[i];
                endcase
            end
        end else begin : g_std
            // Standard selection: off, fall, rise, either
            always_comb begin
                case (edge_mode_e'(mode[2*i +: 2]))
                    EDGE_FALL: hit[i] = fall;
                    EDGE_RISE: hit[i] = rise;
                    EDGE_BOTH: hit[i] = rise | fall;
                    default:   hit[i] = 1'b0;
                endcase
            end
        end
    end

    // Cycles since reset release, saturating, for the delay check
    logic [1:0] up_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)               up_cnt <= '0;
        else if (up_cnt != 2'd3)  up_cnt <= up_cnt + 2'd1;
    end

    assert_sync_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (up_cnt >= 2'd2) |-> (level == $past(pin, 2)));
endmodule

// File: rtl/csp_socket.sv
// Module: one socket's event flags, enables, modes, status decode and
// 16-bit I/O qualifier. Write strobes arrive already decoded by the top.
// Assumes a high level on a battery-detect pin means asserted.
module csp_socket
    import csp_pkg::*;
#(
    parameter int W = PINS_PER_SOCK
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   pin,
    input  logic           win16,
    input  logic [W-1:0]   evt_clr,
    input  logic           ena_we,
    input  logic           modlo_we,
    input  logic           modhi_we,
    input  logic           ctl_we,
    input  logic [7:0]     wdata,
    output logic [W-1:0]   raw,
    output logic [7:0]     decoded,
    output logic [W-1:0]   events,
    output logic [W-1:0]   enables,
    output logic [2*W-1:0] modes,
    output logic           io_mode,
    output logic           io16,
    output logic           irq_part
);
    logic [W-1:0] hit;
    batt_e        batt;
    logic         present;

    csp_edge_det #(.W(W), .EXT_BIT(PIN_EXT)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (pin),
        .mode  (modes),
        .level (raw),
        .hit   (hit)
    );

    // Sticky flags: set by triggers, cleared by write-1, set wins a race
    always_ff @(posedge clk) begin
        if (!rst_n) events <= '0;
        else        events <= (events & ~evt_clr) | hit;
    end

    // Configuration registers written from the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enables <= '0;
            modes   <= '0;
            io_mode <= 1'b0;
        end else begin
            if (ena_we)   enables    <= wdata[W-1:0];
            if (modlo_we) modes[7:0]  <= wdata;
            if (modhi_we) modes[15:8] <= wdata;
            if (ctl_we)   io_mode    <= wdata[0];
        end
    end

    // Battery condition from the two battery-detect levels
    always_comb begin
        if (!raw[PIN_BAT1])      batt = BATT_DEAD;
        else if (!raw[PIN_BAT2]) batt = BATT_WARN;
        else                     batt = BATT_GOOD;
    end

    assign present  = ~raw[PIN_CD1] & ~raw[PIN_CD2];
    assign decoded  = {2'b00, raw[PIN_VS2], raw[PIN_VS1], raw[PIN_WP],
                       batt, present};
    assign io16     = io_mode & win16 & ~raw[PIN_WP];
    assign irq_part = |(events & enables);

    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(events) & ~$past(evt_clr) & ~events) == '0));

    assert_clear_race_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit & evt_clr) != '0) |=> ((events & $past(hit & evt_clr)) == $past(hit & evt_clr)));

    assert_io16_narrow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !win16 |-> !io16);

    for (genvar i = 0; i < PIN_EXT; i++) begin : g_quiet
        assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (modes[2*i +: 2] == 2'd0 && !events[i] && !evt_clr[i]) |=> !events[i]);
    end
endmodule

// File: rtl/csp_port_ctrl.sv
// Module: top of the card status port. Holds NSOCK socket slices,
// decodes the register bus and merges the interrupt.
// Assumes a single-cycle write strobe and a combinational read.
module csp_port_ctrl
    import csp_pkg::*;
#(
    parameter  int NSOCK = 2,
    localparam int SEL_W = (NSOCK > 1) ? $clog2(NSOCK) : 1,
    localparam int AW    = SEL_W + 3,
    localparam int PW    = PINS_PER_SOCK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSOCK*PW-1:0] pin_in,
    input  logic [NSOCK-1:0]  io_win16,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              irq,
    output logic [NSOCK-1:0]  io16_q
);
    logic [SEL_W-1:0] sel;
    logic [2:0]       off;
    logic [PW-1:0]    raw_v  [NSOCK];
    logic [7:0]       dec_v  [NSOCK];
    logic [PW-1:0]    evt_v  [NSOCK];
    logic [PW-1:0]    ena_v  [NSOCK];
    logic [2*PW-1:0]  mod_v  [NSOCK];
    logic             ctl_v  [NSOCK];
    logic [NSOCK-1:0] irq_v;

    assign sel = bus_addr[AW-1:3];
    assign off = bus_addr[2:0];

    for (genvar s = 0; s < NSOCK; s++) begin : g_sock
        logic hit_sel;
        assign hit_sel = bus_wr && (sel == SEL_W'(s));

        csp_socket #(.W(PW)) u_sock (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin      (pin_in[s*PW +: PW]),
            .win16    (io_win16[s]),
            .evt_clr  ((hit_sel && off == OFF_EVT) ? bus_wdata[PW-1:0] : '0),
            .ena_we   (hit_sel && off == OFF_ENA),
            .modlo_we (hit_sel && off == OFF_MODLO),
            .modhi_we (hit_sel && off == OFF_MODHI),
            .ctl_we   (hit_sel && off == OFF_CTL),
            .wdata    (bus_wdata),
            .raw      (raw_v[s]),
            .decoded  (dec_v[s]),
            .events   (evt_v[s]),
            .enables  (ena_v[s]),
            .modes    (mod_v[s]),
            .io_mode  (ctl_v[s]),
            .io16     (io16_q[s]),
            .irq_part (irq_v[s])
        );
    end

    // Read multiplexer over the selected socket's registers
    always_comb begin
        bus_rdata = '0;
        for (int s = 0; s < NSOCK; s++) begin
            if (sel == SEL_W'(s)) begin
                case (off)
                    OFF_RAW:   bus_rdata = raw_v[s];
                    OFF_DEC:   bus_rdata = dec_v[s];
                    OFF_EVT:   bus_rdata = evt_v[s];
                    OFF_ENA:   bus_rdata = ena_v[s];
                    OFF_MODLO: bus_rdata = mod_v[s][7:0];
                    OFF_MODHI: bus_rdata = mod_v[s][15:8];
                    OFF_CTL:   bus_rdata = {7'd0, ctl_v[s]};
                    default:   bus_rdata = '0;
                endcase
            end
        end
    end

    assign irq = |irq_v;

    assert_irq_after_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq && io16_q == '0));
endmodule

// File: tb/sim_csp_port_ctrl.sv
module sim_csp_port_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] pin_in;
    logic [1:0]  io_win16;
    logic [3:0]  bus_addr;
    logic        bus_wr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic        irq;
    logic [1:0]  io16_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // {socket A pins, expected decoded byte}
    localparam logic [15:0] VEC [8] = '{
        16'hFF38, 16'h6001, 16'h4003, 16'h2005,
        16'h0005, 16'h6D18, 16'h7220, 16'h6331
    };

    always #(CLK_PERIOD/2) clk = ~clk;

    csp_port_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .io_win16(io_win16),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .io16_q(io16_q)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        rst_n = 1'b0; pin_in = 16'hFFFF; io_win16 = 2'b00;
        bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R11 reset state
        rd(4'd2, v);  check("R11 events A", v, 8'h00);
        rd(4'd3, v);  check("R11 enables A", v, 8'h00);
        rd(4'd4, v);  check("R11 mode lo A", v, 8'h00);
        rd(4'd13, v); check("R11 mode hi B", v, 8'h00);
        rd(4'd6, v);  check("R11 io mode A", v, 8'h00);
        check("R11 irq", {7'd0, irq}, 8'h00);
        check("R11 io16", {6'd0, io16_q}, 8'h00);

        // R1 synchronizer delay
        @(negedge clk); pin_in[7:0] = 8'hFE;
        @(posedge clk); @(negedge clk);
        rd(4'd0, v); check("R1 one edge", v, 8'hFF);
        @(posedge clk); @(negedge clk);
        rd(4'd0, v); check("R1 two edges", v, 8'hFE);

        // R7 R8 R9 decode table
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); pin_in[7:0] = VEC[i][15:8];
            settle();
            rd(4'd0, v); check("R1 raw", v, VEC[i][15:8]);
            rd(4'd1, v); check("R7 R8 R9 decoded", v, VEC[i][7:0]);
        end

        @(negedge clk); pin_in[7:0] = 8'hFF; settle();
        wr(4'd2, 8'hFF);
        rd(4'd2, v); check("R4 clear all", v, 8'h00);

        // R2 bit 0 modes
        @(negedge clk); pin_in[0] = 1'b0; settle();
        @(negedge clk); pin_in[0] = 1'b1; settle();
        rd(4'd2, v); check("R2 off", v, 8'h00);
        wr(4'd4, 8'h01);
        @(negedge clk); pin_in[0] = 1'b0; settle();
        rd(4'd2, v); check("R2 fall sets", v, 8'h01);
        wr(4'd2, 8'h00);
        rd(4'd2, v); check("R4 write zero", v, 8'h01);
        wr(4'd2, 8'h01);
        @(negedge clk); pin_in[0] = 1'b1; settle();
        rd(4'd2, v); check("R2 fall ignores rise", v, 8'h00);
        wr(4'd4, 8'h02);
        @(negedge clk); pin_in[0] = 1'b0; settle();
        rd(4'd2, v); check("R2 rise ignores fall", v, 8'h00);
        @(negedge clk); pin_in[0] = 1'b1; settle();
        rd(4'd2, v); check("R2 rise sets", v, 8'h01);
        wr(4'd2, 8'h01);
        wr(4'd4, 8'h03);
        @(negedge clk); pin_in[0] = 1'b0; settle();
        rd(4'd2, v); check("R2 both fall", v, 8'h01);
        wr(4'd2, 8'h01);
        @(negedge clk); pin_in[0] = 1'b1; settle();
        rd(4'd2, v); check("R2 both rise", v, 8'h01);
        wr(4'd2, 8'h01);
        wr(4'd4, 8'h00);

        // R3 pin 7 extended modes
        wr(4'd5, 8'h40);
        @(negedge clk); pin_in[7] = 1'b0; settle();
        rd(4'd2, v); check("R3 rise ignores fall", v, 8'h00);
        @(negedge clk); pin_in[7] = 1'b1; settle();
        rd(4'd2, v); check("R3 rise sets", v, 8'h80);
        wr(4'd2, 8'h80);
        wr(4'd5, 8'h00);
        @(negedge clk); pin_in[7] = 1'b0; settle();
        rd(4'd2, v); check("R3 fall sets", v, 8'h80);
        wr(4'd2, 8'h80);
        wr(4'd5, 8'hC0); settle();
        rd(4'd2, v); check("R3 level low", v, 8'h80);
        wr(4'd2, 8'h80);
        rd(4'd2, v); check("R5 clear while active", v, 8'h80);
        @(negedge clk); pin_in[7] = 1'b1; settle();
        wr(4'd2, 8'h80);
        rd(4'd2, v); check("R3 level released", v, 8'h00);
        wr(4'd5, 8'h80);
        @(negedge clk); pin_in[7] = 1'b0; settle();
        rd(4'd2, v); check("R3 both fall", v, 8'h80);
        wr(4'd2, 8'h80);
        @(negedge clk); pin_in[7] = 1'b1; settle();
        rd(4'd2, v); check("R3 both rise", v, 8'h80);
        wr(4'd2, 8'h80);
        wr(4'd5, 8'h40);

        // R6 interrupt masking across sockets
        wr(4'd10, 8'hFF);
        wr(4'd12, 8'h01);
        wr(4'd11, 8'h01);
        @(negedge clk); pin_in[8] = 1'b0; settle();
        check("R6 irq on", {7'd0, irq}, 8'h01);
        wr(4'd11, 8'h00);
        check("R6 masked", {7'd0, irq}, 8'h00);
        wr(4'd3, 8'h01);
        check("R6 other socket enable", {7'd0, irq}, 8'h00);
        wr(4'd11, 8'h01);
        check("R6 re-enabled", {7'd0, irq}, 8'h01);
        wr(4'd10, 8'h01);
        check("R6 cleared", {7'd0, irq}, 8'h00);

        // R10 I/O qualifier
        wr(4'd6, 8'h01);
        @(negedge clk); io_win16 = 2'b11; pin_in[2] = 1'b0; pin_in[10] = 1'b0; settle();
        check("R10 wide window", {6'd0, io16_q}, 8'h01);
        @(negedge clk); io_win16 = 2'b10; #1;
        check("R10 narrow ignored", {6'd0, io16_q}, 8'h00);
        @(negedge clk); io_win16 = 2'b01; pin_in[2] = 1'b1; settle();
        check("R10 pin high", {6'd0, io16_q}, 8'h00);
        @(negedge clk); pin_in[2] = 1'b0; settle();
        wr(4'd6, 8'h00);
        check("R10 io mode off", {6'd0, io16_q}, 8'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule